// File: doc/BRIEF.md
# Signed-Count Bidirectional Barrel Shifter

This block shifts a 40-bit operand by up to 16 places in one pipeline stage. A single two's-complement count sets both direction and distance: a positive count moves bits toward the least significant end, a negative count moves them toward the most significant end, and zero leaves the operand as it is. Right shifts are arithmetic or logical under a mode input. Left shifts always bring in zeros.

The operand comes from one of two 40-bit accumulator inputs or from a 16-bit data bus. A bus word is placed inside the 40-bit datapath at a position that depends on the direction, so the bits it loses stay in the wide result. For a right shift the word sits in bits 31..16. For a left shift it sits in bits 15..0. The block returns the full 40-bit result for signal-processing use, a 16-bit slice for general-purpose use, and a zero flag. All outputs are registered.

Top module: `sc_barrel_shifter`

## Requirements
- R1: Outputs are registered. `valid_o` equals `valid_i` from the previous clock. When `valid_i` is low, `wide_o`, `narrow_o` and `zero_o` keep their values. While reset is asserted, all outputs are zero.
- R2: `count_i` is a 6-bit two's-complement value. A positive count shifts right and a negative count shifts left. A count of zero passes the placed operand through unchanged. A magnitude above 16, including -32, acts as 16.
- R3: A logical right shift (`arith_i`=0) fills the vacated upper bits of the 40-bit result with zeros.
- R4: A left shift fills the vacated lower bits with zeros, whatever the value of `arith_i`.
- R5: An arithmetic right shift (`arith_i`=1) of an accumulator operand fills the vacated upper bits with a copy of operand bit 39.
- R6: `src_sel_i` chooses the operand: 0 selects `acc_a_i`, 1 selects `acc_b_i`, and 2 or 3 selects `bus_i`.
- R7: A bus operand is placed before the shift. For a count of zero or more, it goes to bits 31..16 with bits 15..0 cleared, and bits 39..32 equal to `bus_i[15]` when `arith_i`=1 and zero otherwise. For a negative count, it goes to bits 15..0 with bits 39..16 cleared.
- R8: `narrow_o` is bits 31..16 of the 40-bit result when the count is zero or more, and bits 15..0 when the count is negative.
- R9: For an accumulator source, `zero_o` is 1 exactly when the 40-bit result is zero. For a bus source, `zero_o` is 1 exactly when `narrow_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept the inputs on this clock |
| src_sel_i | input | 2 | Operand source: 0 acc A, 1 acc B, 2 or 3 bus |
| acc_a_i | input | 40 | First accumulator operand |
| acc_b_i | input | 40 | Second accumulator operand |
| bus_i | input | 16 | Data bus operand |
| count_i | input | 6 | Signed shift count: positive shifts right, negative shifts left |
| arith_i | input | 1 | 1 = arithmetic right shift, 0 = logical |
| valid_o | output | 1 | Result valid |
| wide_o | output | 40 | 40-bit shift result |
| narrow_o | output | 16 | 16-bit result slice |
| zero_o | output | 1 | Zero flag for the result |

## Verification
The in-line assertions check on every cycle:
- the one-cycle valid pipeline and the hold of the outputs while idle;
- that a decoded magnitude never exceeds 16;
- the zero-count pass-through of accumulator A;
- the zero bit 0 after a left shift and the zero bit 39 after a logical right shift.

Exact bit patterns come only from the bench's scenarios. These are the sign fill of arithmetic shifts, the direction-dependent placement of bus data, the clamping of out-of-range counts, the selection of the narrow slice and the zero flag. The bench sweeps every count from -16 to +16, plus out-of-range values, over all sources and both right-shift modes, and compares against a behavioural model.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int unsigned DATA_W  = 40;
  localparam int unsigned BUS_W   = 16;
  localparam int unsigned CNT_W   = 6;
  localparam int unsigned MAX_SH  = 16;

  typedef enum logic [1:0] {
    SRC_ACC_A = 2'd0,
    SRC_ACC_B = 2'd1,
    SRC_BUS   = 2'd2,
    SRC_BUS_2 = 2'd3
  } src_e;

  function automatic logic is_bus(input logic [1:0] sel);
    return sel[1];
  endfunction
endpackage

// File: rtl/sbs_count_decode.sv
module sbs_count_decode #(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned MAX_SH = 16,
  localparam int unsigned MAG_W = $clog2(MAX_SH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  output logic             left_o,
  output logic [MAG_W-1:0] mag_o
);
  localparam int unsigned ABS_W = CNT_W + 1;

  logic [ABS_W-1:0] abs_cnt;
  logic [ABS_W-1:0] max_ext;

  assign left_o  = count_i[CNT_W-1];
  assign max_ext = ABS_W'(MAX_SH);

  always_comb begin
    if (left_o) abs_cnt = ABS_W'(0) - {count_i[CNT_W-1], count_i};
    else        abs_cnt = {1'b0, count_i};
  end

  // saturate distance at the single-cycle limit
  assign mag_o = (abs_cnt > max_ext) ? MAG_W'(MAX_SH) : abs_cnt[MAG_W-1:0];

  p_mag_clamp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mag_o <= MAG_W'(MAX_SH));
endmodule

// File: rtl/sbs_operand_place.sv
module sbs_operand_place
  import sbs_pkg::*;
#(
  parameter int unsigned DATA_W = 40,
  parameter int unsigned BUS_W  = 16
) (
  input  logic [1:0]        src_sel_i,
  input  logic [DATA_W-1:0] acc_a_i,
  input  logic [DATA_W-1:0] acc_b_i,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic              left_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] opnd_o
);
  localparam int unsigned HI_W = DATA_W - 2 * BUS_W;

  logic [DATA_W-1:0] bus_right;
  logic [DATA_W-1:0] bus_left;
  logic              bus_sign;

  assign bus_sign  = arith_i & bus_i[BUS_W-1];
  // right: word in the middle field, sign pre-extended into the guard bits
  assign bus_right = {{HI_W{bus_sign}}, bus_i, {BUS_W{1'b0}}};
  // left: word at the bottom so upper bits catch what moves out
  assign bus_left  = {{(DATA_W - BUS_W){1'b0}}, bus_i};

  always_comb begin
    unique case (src_e'(src_sel_i))
      SRC_ACC_A:           opnd_o = acc_a_i;
      SRC_ACC_B:           opnd_o = acc_b_i;
      SRC_BUS, SRC_BUS_2:  opnd_o = left_i ? bus_left : bus_right;
      default:             opnd_o = '0;
    endcase
  end
endmodule

// File: rtl/sbs_shift_core.sv
module sbs_shift_core #(
  parameter int unsigned DATA_W = 40,
  parameter int unsigned MAG_W  = 5
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              left_i,
  input  logic              fill_i,
  input  logic [MAG_W-1:0]  mag_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] stg [MAG_W+1];

  assign stg[0] = opnd_i;

  for (genvar k = 0; k < MAG_W; k++) begin : g_stage
    localparam int unsigned SH = 1 << k;
    logic [DATA_W-1:0] sh_l;
    logic [DATA_W-1:0] sh_r;
    assign sh_l = {stg[k][DATA_W-1-SH:0], {SH{1'b0}}};
    assign sh_r = {{SH{fill_i}}, stg[k][DATA_W-1:SH]};
    assign stg[k+1] = !mag_i[k] ? stg[k] : (left_i ? sh_l : sh_r);
  end

  assign res_o = stg[MAG_W];
endmodule

// File: rtl/sc_barrel_shifter.sv
module sc_barrel_shifter
  import sbs_pkg::*;
#(
  parameter int unsigned DATA_W = 40,
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned MAX_SH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        src_sel_i,
  input  logic [DATA_W-1:0] acc_a_i,
  input  logic [DATA_W-1:0] acc_b_i,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              arith_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] wide_o,
  output logic [BUS_W-1:0]  narrow_o,
  output logic              zero_o
);
  localparam int unsigned MAG_W = $clog2(MAX_SH + 1);

  logic              left;
  logic [MAG_W-1:0]  mag;
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] res;
  logic [BUS_W-1:0]  res_narrow;
  logic              fill;
  logic              res_zero;

  sbs_count_decode #(.CNT_W(CNT_W), .MAX_SH(MAX_SH)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_i (count_i),
    .left_o  (left),
    .mag_o   (mag)
  );

  sbs_operand_place #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_place (
    .src_sel_i (src_sel_i),
    .acc_a_i   (acc_a_i),
    .acc_b_i   (acc_b_i),
    .bus_i     (bus_i),
    .left_i    (left),
    .arith_i   (arith_i),
    .opnd_o    (opnd)
  );

  assign fill = arith_i & opnd[DATA_W-1];

  sbs_shift_core #(.DATA_W(DATA_W), .MAG_W(MAG_W)) u_core (
    .opnd_i (opnd),
    .left_i (left),
    .fill_i (fill),
    .mag_i  (mag),
    .res_o  (res)
  );

  assign res_narrow = left ? res[BUS_W-1:0] : res[2*BUS_W-1:BUS_W];
  assign res_zero   = is_bus(src_sel_i) ? (res_narrow == '0) : (res == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wide_o   <= '0;
      narrow_o <= '0;
      zero_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        wide_o   <= res;
        narrow_o <= res_narrow;
        zero_o   <= res_zero;
      end
    end
  end

  p_valid_pipe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(wide_o) && $stable(narrow_o) && $stable(zero_o)));

  p_zero_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && count_i == '0 && src_sel_i == SRC_ACC_A) |=> wide_o == $past(acc_a_i));

  p_left_lsb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && count_i[CNT_W-1]) |=> !wide_o[0]);

  p_logic_msb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !arith_i && !count_i[CNT_W-1] && count_i != '0 && !src_sel_i[1])
      |=> !wide_o[DATA_W-1]);
endmodule

// File: tb/sc_barrel_shifter_bench.sv
module sc_barrel_shifter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  src_sel_i = '0;
  logic [39:0] acc_a_i = '0;
  logic [39:0] acc_b_i = '0;
  logic [15:0] bus_i = '0;
  logic [5:0]  count_i = '0;
  logic        arith_i = 1'b0;
  logic        valid_o;
  logic [39:0] wide_o;
  logic [15:0] narrow_o;
  logic        zero_o;

  int total = 0;
  int bad = 0;

  logic [39:0] e_wide = '0;
  logic [15:0] e_narrow = '0;
  logic        e_zero = 1'b0;
  logic        e_valid = 1'b0;
  string       e_tag = "R1";

  always #2 clk = ~clk;

  sc_barrel_shifter u_sc_barrel_shifter (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .src_sel_i(src_sel_i),
    .acc_a_i(acc_a_i), .acc_b_i(acc_b_i), .bus_i(bus_i), .count_i(count_i),
    .arith_i(arith_i), .valid_o(valid_o), .wide_o(wide_o),
    .narrow_o(narrow_o), .zero_o(zero_o)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 valid", 40'(valid_o), 40'(e_valid));
    chk({e_tag, " wide"}, wide_o, e_wide);
    chk("R8 narrow", 40'(narrow_o), 40'(e_narrow));
    chk("R9 zero", 40'(zero_o), 40'(e_zero));
  endtask

  // behavioural reference
  task automatic model(input int cnt, input int sel, input logic ar,
                       input logic [39:0] a, input logic [39:0] b, input logic [15:0] w);
    logic [39:0] op;
    logic [39:0] r;
    int mag;
    bit lft;
    lft = cnt < 0;
    mag = lft ? -cnt : cnt;
    if (mag > 16) mag = 16;
    if (sel == 0) op = a;
    else if (sel == 1) op = b;
    else if (lft) op = {24'h0, w};
    else op = {{8{ar & w[15]}}, w, 16'h0};
    if (lft) r = op << mag;
    else if (ar) r = 40'($signed(op) >>> mag);
    else r = op >> mag;
    e_wide = r;
    e_narrow = lft ? r[15:0] : r[31:16];
    e_zero = (sel >= 2) ? (e_narrow == 16'h0) : (r == 40'h0);
    if (sel >= 2) e_tag = "R7 R6";
    else if (cnt == 0 || mag == 16) e_tag = "R2 R6";
    else if (lft) e_tag = "R4 R6";
    else if (ar) e_tag = "R5 R6";
    else e_tag = "R3 R6";
  endtask

  task automatic step(input bit v, input int cnt, input int sel, input logic ar);
    valid_i = v;
    count_i = 6'(cnt);
    src_sel_i = 2'(sel);
    arith_i = ar;
    if (v) model(cnt, sel, ar, acc_a_i, acc_b_i, bus_i);
    e_valid = v;
    if (!v) e_tag = "R1 hold";
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    @(negedge clk);
    compare_all(); // R1 reset values
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    for (int p = 0; p < 2; p++) begin
      acc_a_i = p == 0 ? 40'h9A_5C3E_7181 : 40'h00_0000_8001;
      acc_b_i = p == 0 ? 40'h3F_0F00_F0A5 : 40'hFF_FFFF_0000;
      bus_i   = p == 0 ? 16'hB3C1 : 16'h4D2A;
      for (int sel = 0; sel < 4; sel++)
        for (int ar = 0; ar < 2; ar++) begin
          for (int c = -16; c <= 16; c++) step(1'b1, c, sel, ar[0]);
          step(1'b1, -32, sel, ar[0]);   // R2 clamp
          step(1'b1, 31, sel, ar[0]);
          step(1'b1, -20, sel, ar[0]);
          step(1'b0, 5, sel, ar[0]);     // R1 hold
        end
    end
    // R9 zero corners
    acc_a_i = 40'h00_0000_FFFF; bus_i = 16'h0001;
    step(1'b1, 16, 0, 1'b0);
    step(1'b1, 1, 2, 1'b0);
    step(1'b1, -16, 3, 1'b0);
    step(1'b1, 0, 2, 1'b1);
    step(1'b0, 0, 0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule